// File: doc/BRIEF.md
# Memory-Mapped Peripheral Bus Decoder

This block connects a 16-bit processor bus to the resources of a small system. The top four address bits choose a region. Region 0 is a 128-word synchronous program/data RAM. Region 1 is a 16-bit LED output register. Region 2 is a bank of eight seven-segment digit registers. Region 3 is a read-only port that samples the switch inputs. The block forms the write enables by combining the region select with the processor's write strobe. It returns read data through a multiplexer.

Every read is answered exactly one clock after the address is presented, whichever region it targets. This matches the one-cycle latency of the synchronous RAM. To get this, the region select and digit index are registered, and the registered copies steer the read multiplexer. Digit registers hold active-low segment patterns, so all ones means a blank digit. Reset blanks every digit and clears the LEDs.

Top module: `mmio_decoder`

## Requirements
- R1: When cpu_addr[15:12] is 0 and cpu_we is 1, word cpu_addr[6:0] of the RAM takes cpu_wdata at the clock edge. A read of that word returns it on cpu_rdata one cycle after the address is presented. A read in the same cycle as a write to that word returns the old word.
- R2: Bits 11:7 of a RAM address are ignored, so 0x0F85 and 0x0005 name the same RAM word.
- R3: A cycle with cpu_we at 0 changes no RAM word, LED bit or digit.
- R4: When cpu_addr[15:12] is 1 and cpu_we is 1, led_q takes cpu_wdata at the clock edge, whatever the low 12 address bits are. A read in region 1 returns led_q one cycle later.
- R5: When cpu_addr[15:12] is 2 and cpu_we is 1, digit cpu_addr[2:0] takes cpu_wdata[6:0]. Digit 0 is the leftmost digit and sits at seg_q[6:0], and digit k sits at seg_q[7k+6:7k]. A read in region 2 returns that digit's pattern, zero-extended, one cycle later.
- R6: A read with cpu_addr[15:12] equal to 3 returns, one cycle later, the value that sw_in had at the clock edge where the address was presented.
- R7: Writes with cpu_addr[15:12] equal to 3, or anywhere from 4 to 15, change no RAM word, LED bit or digit.
- R8: A read with cpu_addr[15:12] anywhere from 4 to 15 returns 0 one cycle later.
- R9: While rst_n is low, led_q is 0, every digit is 7'h7F (blank) and cpu_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 16 | Processor write data |
| cpu_we | input | 1 | Processor write strobe |
| cpu_rdata | output | 16 | Read data, one cycle after the address |
| sw_in | input | 16 | Switch levels |
| led_q | output | 16 | LED output register |
| seg_q | output | 56 | Eight digit patterns, active low, digit 0 in the low bits |

## Verification
Writes change led_q, seg_q and the RAM at the clock edge that samples the strobe. Every read is answered on cpu_rdata one edge after the address is presented. The bench drives each bus cycle just after a falling edge and waits for the rising edge. It then samples cpu_rdata, led_q and seg_q on the following falling edge. It compares them with a bench model that is updated in the same order, which includes the old-word result of a RAM read that coincides with a write to the same word. Seeded random traffic across all sixteen regions is mixed with directed cases for aliasing, ignored writes and reset.

// File: rtl/mmio_pkg.sv
package mmio_pkg;
   typedef enum logic [2:0] {
      RGN_NONE = 3'd0,
      RGN_RAM  = 3'd1,
      RGN_LED  = 3'd2,
      RGN_DISP = 3'd3,
      RGN_SW   = 3'd4
   } region_t;
endpackage

// File: rtl/mmio_addr_dec.sv
module mmio_addr_dec
   import mmio_pkg::*;
#(
   parameter int         NIB_W    = 4,
   parameter logic [3:0] RAM_NIB  = 4'h0,
   parameter logic [3:0] LED_NIB  = 4'h1,
   parameter logic [3:0] DISP_NIB = 4'h2,
   parameter logic [3:0] SW_NIB   = 4'h3
) (
   input  logic [NIB_W-1:0] nibble,
   output region_t          region
);
   if (NIB_W != 4) begin : g_bad_nib
      $error("mmio_addr_dec: region field must be 4 bits");
   end
   if (RAM_NIB == LED_NIB || RAM_NIB == DISP_NIB || RAM_NIB == SW_NIB ||
       LED_NIB == DISP_NIB || LED_NIB == SW_NIB || DISP_NIB == SW_NIB) begin : g_bad_map
      $error("mmio_addr_dec: region codes must be distinct");
   end

   always_comb begin
      if (nibble == RAM_NIB)       region = RGN_RAM;
      else if (nibble == LED_NIB)  region = RGN_LED;
      else if (nibble == DISP_NIB) region = RGN_DISP;
      else if (nibble == SW_NIB)   region = RGN_SW;
      else                         region = RGN_NONE;
   end
endmodule

// File: rtl/mmio_ram.sv
module mmio_ram #(
   parameter int AW = 7,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] q
);
   localparam int DEPTH = 1 << AW;

   if (AW < 1 || AW > 10) begin : g_bad_aw
      $error("mmio_ram: address width out of range");
   end

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      q <= mem[addr];
      if (we) mem[addr] <= wdata;
   end
endmodule

// File: rtl/mmio_out_regs.sv
module mmio_out_regs #(
   parameter int DATA_W   = 16,
   parameter int NUM_DISP = 8,
   parameter int SEG_W    = 7,
   parameter int IDX_W    = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      led_we,
   input  logic                      disp_we,
   input  logic [IDX_W-1:0]          disp_idx,
   input  logic [DATA_W-1:0]         wdata,
   output logic [DATA_W-1:0]         led_q,
   output logic [NUM_DISP*SEG_W-1:0] seg_q
);
   if ((1 << IDX_W) < NUM_DISP) begin : g_bad_idx
      $error("mmio_out_regs: index too narrow for digit count");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      led_q <= '0;
      else if (led_we) led_q <= wdata;
   end

   for (genvar gi = 0; gi < NUM_DISP; gi++) begin : g_digit
      logic [SEG_W-1:0] pat;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pat <= '1;
         else if (disp_we && disp_idx == IDX_W'(gi))
            pat <= wdata[SEG_W-1:0];
      end
      assign seg_q[gi*SEG_W +: SEG_W] = pat;
   end
endmodule

// File: rtl/mmio_decoder.sv
module mmio_decoder
   import mmio_pkg::*;
#(
   parameter int         ADDR_W   = 16,
   parameter int         DATA_W   = 16,
   parameter int         RAM_AW   = 7,
   parameter int         NUM_DISP = 8,
   parameter int         SEG_W    = 7,
   parameter logic [3:0] RAM_NIB  = 4'h0,
   parameter logic [3:0] LED_NIB  = 4'h1,
   parameter logic [3:0] DISP_NIB = 4'h2,
   parameter logic [3:0] SW_NIB   = 4'h3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [ADDR_W-1:0]         cpu_addr,
   input  logic [DATA_W-1:0]         cpu_wdata,
   input  logic                      cpu_we,
   output logic [DATA_W-1:0]         cpu_rdata,
   input  logic [DATA_W-1:0]         sw_in,
   output logic [DATA_W-1:0]         led_q,
   output logic [NUM_DISP*SEG_W-1:0] seg_q
);
   localparam int NIB_LSB = ADDR_W - 4;
   localparam int IDX_W   = (NUM_DISP > 1) ? $clog2(NUM_DISP) : 1;

   if (DATA_W <= SEG_W) begin : g_bad_seg
      $error("mmio_decoder: data word must be wider than a digit");
   end
   if (RAM_AW + 4 > ADDR_W || IDX_W + 4 > ADDR_W) begin : g_bad_addr
      $error("mmio_decoder: address too narrow for region layout");
   end

   region_t region, region_q;
   logic [IDX_W-1:0]  idx_q;
   logic [DATA_W-1:0] sw_q;
   logic [DATA_W-1:0] ram_q;
   logic [SEG_W-1:0]  disp_rd;
   logic              unused_addr_bits;

   assign unused_addr_bits = ^cpu_addr;

   mmio_addr_dec #(
      .NIB_W(4), .RAM_NIB(RAM_NIB), .LED_NIB(LED_NIB),
      .DISP_NIB(DISP_NIB), .SW_NIB(SW_NIB)
   ) u_dec (
      .nibble (cpu_addr[ADDR_W-1:NIB_LSB]),
      .region (region)
   );

   mmio_ram #(.AW(RAM_AW), .DW(DATA_W)) u_ram (
      .clk   (clk),
      .we    (cpu_we && region == RGN_RAM),
      .addr  (cpu_addr[RAM_AW-1:0]),
      .wdata (cpu_wdata),
      .q     (ram_q)
   );

   mmio_out_regs #(
      .DATA_W(DATA_W), .NUM_DISP(NUM_DISP), .SEG_W(SEG_W), .IDX_W(IDX_W)
   ) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .led_we   (cpu_we && region == RGN_LED),
      .disp_we  (cpu_we && region == RGN_DISP),
      .disp_idx (cpu_addr[IDX_W-1:0]),
      .wdata    (cpu_wdata),
      .led_q    (led_q),
      .seg_q    (seg_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         region_q <= RGN_NONE;
         idx_q    <= '0;
         sw_q     <= '0;
      end else begin
         region_q <= region;
         idx_q    <= cpu_addr[IDX_W-1:0];
         sw_q     <= sw_in;
      end
   end

   always_comb begin
      disp_rd = '0;
      for (int i = 0; i < NUM_DISP; i++)
         if (idx_q == IDX_W'(i)) disp_rd = seg_q[i*SEG_W +: SEG_W];
   end

   always_comb begin
      unique case (region_q)
         RGN_RAM:  cpu_rdata = ram_q;
         RGN_LED:  cpu_rdata = led_q;
         RGN_DISP: cpu_rdata = {{(DATA_W-SEG_W){1'b0}}, disp_rd};
         RGN_SW:   cpu_rdata = sw_q;
         default:  cpu_rdata = '0;
      endcase
   end
endmodule

// File: rtl/mmio_decoder_chk.sv
module mmio_decoder_chk #(
   parameter int         ADDR_W   = 16,
   parameter int         DATA_W   = 16,
   parameter int         NUM_DISP = 8,
   parameter int         SEG_W    = 7,
   parameter logic [3:0] LED_NIB  = 4'h1,
   parameter logic [3:0] DISP_NIB = 4'h2,
   parameter logic [3:0] SW_NIB   = 4'h3
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [ADDR_W-1:0]         cpu_addr,
   input logic [DATA_W-1:0]         cpu_wdata,
   input logic                      cpu_we,
   input logic [DATA_W-1:0]         cpu_rdata,
   input logic [DATA_W-1:0]         sw_in,
   input logic [DATA_W-1:0]         led_q,
   input logic [NUM_DISP*SEG_W-1:0] seg_q
);
   logic [3:0] nib;
   assign nib = cpu_addr[ADDR_W-1 -: 4];

   assert_led_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_we && nib == LED_NIB) |=> led_q == $past(cpu_wdata));

   assert_led_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(cpu_we && nib == LED_NIB) |=> $stable(led_q));

   assert_seg_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(cpu_we && nib == DISP_NIB) |=> $stable(seg_q));

   assert_sw_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (nib == SW_NIB) |=> cpu_rdata == $past(sw_in));

   assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (nib > SW_NIB) |=> cpu_rdata == '0);
endmodule

bind mmio_decoder mmio_decoder_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_DISP(NUM_DISP), .SEG_W(SEG_W),
   .LED_NIB(LED_NIB), .DISP_NIB(DISP_NIB), .SW_NIB(SW_NIB)
) u_chk (.*);

// File: tb/mmio_decoder_tb.sv
module mmio_decoder_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [15:0] cpu_wdata = '0;
   logic        cpu_we = 1'b0;
   logic [15:0] cpu_rdata;
   logic [15:0] sw_in = '0;
   logic [15:0] led_q;
   logic [55:0] seg_q;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [15:0] ram_m [128];
   logic [15:0] led_m = '0;
   logic [6:0]  disp_m [8];

   always #5 clk = ~clk;

   mmio_decoder u_dut (.*);

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [55:0] seg_exp();
      logic [55:0] s;
      for (int i = 0; i < 8; i++) s[i*7 +: 7] = disp_m[i];
      return s;
   endfunction

   // one bus cycle: drive now (after a falling edge), expect the read one edge later
   task automatic bus(input logic [15:0] a, input logic [15:0] d,
                      input bit w, input string req);
      logic [15:0] exp;
      cpu_addr = a; cpu_wdata = d; cpu_we = w;
      case (a[15:12])
         4'h0: begin exp = ram_m[a[6:0]]; if (w) ram_m[a[6:0]] = d; end
         4'h1: begin if (w) led_m = d; exp = led_m; end
         4'h2: begin if (w) disp_m[a[2:0]] = d[6:0]; exp = {9'b0, disp_m[a[2:0]]}; end
         4'h3: exp = sw_in;
         default: exp = '0;
      endcase
      @(posedge clk);
      @(negedge clk);
      cpu_we = 1'b0;
      check(req, "rdata", {48'b0, cpu_rdata}, {48'b0, exp});
      check(req, "led", {48'b0, led_q}, {48'b0, led_m});
      check(req, "seg", {8'b0, seg_q}, {8'b0, seg_exp()});
   endtask

   function automatic string tag_of(input logic [3:0] n);
      case (n)
         4'h0: return "R1";
         4'h1: return "R4";
         4'h2: return "R5";
         4'h3: return "R6";
         default: return "R8";
      endcase
   endfunction

   initial begin
      for (int i = 0; i < 8; i++) disp_m[i] = 7'h7F;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      // R9: reset state
      check("R9", "led", {48'b0, led_q}, 64'h0);
      check("R9", "seg", {8'b0, seg_q}, {8'b0, {56{1'b1}}});
      check("R9", "rdata", {48'b0, cpu_rdata}, 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: fill every RAM word, then read a few back
      for (int i = 0; i < 128; i++) bus(16'(i), 16'(i * 517 + 3), 1'b1, "R1");
      bus(16'h0000, 16'h0, 1'b0, "R1");
      bus(16'h007F, 16'h0, 1'b0, "R1");
      bus(16'h0021, 16'hBEEF, 1'b1, "R1");   // same-cycle read returns old word
      bus(16'h0021, 16'h0, 1'b0, "R1");
      // R2: aliasing of bits 11:7
      bus(16'h0F85, 16'hC0DE, 1'b1, "R2");
      bus(16'h0005, 16'h0, 1'b0, "R2");
      // R3: no write without strobe
      bus(16'h0010, 16'hDEAD, 1'b0, "R3");
      bus(16'h0010, 16'h0, 1'b0, "R3");
      bus(16'h1000, 16'h1234, 1'b0, "R3");
      bus(16'h2003, 16'h0000, 1'b0, "R3");
      // R4: LED load at any offset
      bus(16'h1000, 16'hA5C3, 1'b1, "R4");
      bus(16'h1ABC, 16'h0F0F, 1'b1, "R4");
      // R5: digits, leftmost and rightmost, high bits dropped
      bus(16'h2000, 16'hFF40, 1'b1, "R5");
      bus(16'h2007, 16'h0012, 1'b1, "R5");
      bus(16'h2007, 16'h0, 1'b0, "R5");
      // R6: switch read
      sw_in = 16'h5A5A;
      bus(16'h3000, 16'h0, 1'b0, "R6");
      // R7: writes to switch and unmapped regions are ignored
      bus(16'h3000, 16'h1111, 1'b1, "R7");
      bus(16'h4000, 16'h2222, 1'b1, "R7");
      bus(16'hF001, 16'h3333, 1'b1, "R7");
      bus(16'h0000, 16'h0, 1'b0, "R7");
      bus(16'h0001, 16'h0, 1'b0, "R7");
      // R8: unmapped read
      bus(16'hA123, 16'h0, 1'b0, "R8");
      // random traffic over all regions
      for (int k = 0; k < 600; k++) begin
         logic [15:0] a;
         logic [3:0]  n;
         a = 16'($urandom);
         n = ($urandom % 3 == 0) ? 4'($urandom) : 4'($urandom % 4);
         a[15:12] = n;
         sw_in = 16'($urandom);
         bus(a, 16'($urandom), ($urandom % 2) == 1, tag_of(n));
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule